// File: doc/BRIEF.md
# Six-Channel Capture/Compare Timer Unit

This block is a 16-bit timer that only counts up. When it passes its top value it restarts from a programmable reload value. Six channels hang off it. Each channel is set up on its own as a compare output or as an edge capture input.

A compare channel raises its pin when the count matches its active compare value. The pin drops again at the next overflow. Software never writes the active value directly. It writes a shadow copy and arms a per-channel transfer bit, and the new value takes effect at the next overflow. A concurrent mode lets one write to channel 0 load the shadow copy of every channel.

A capture channel latches the timer value when a synchronised input edge of the selected polarity arrives. It can also latch on a software strike. Every channel and the overflow each raise their own sticky interrupt flag. All control and status is reached through a simple single-cycle write port and a combinational read port.

Top module: `cct_unit`

## Requirements
- R1: After reset the counter is 0, the control, reload, transfer-enable, flag, configuration, active and shadow registers all read 0, and the compare pins and interrupt outputs are low.
- R2: While the run bit (address 0, bit 0) is 1, the counter steps by one each clock. When it holds 0xFFFF, the next value is the reload register (address 1). A write to address 2 loads the counter and takes priority over counting. Reading address 2 returns the count.
- R3: Every overflow sets the overflow flag (address 4, bit 6) and drives irq_ovf high.
- R4: A channel whose configuration field bits [1:0] (address 8+i) equal 1 is a compare channel. Its pin goes high in the cycle where the count equals the active value and goes low at overflow. Each match sets its channel flag (address 4, bit i). Pins of channels in any other mode stay low.
- R5: A write to address 16+i goes to the shadow register of channel i (read at 24+i). The active value (read at 16+i) stays unchanged until an overflow occurs while transfer-enable bit i (address 3, a written 1 sets it) is set on a compare channel. That transfer clears the bit. Without the bit, no transfer happens.
- R6: At a transferring overflow the pin is evaluated against the new value. An active value equal to the reload keeps the pin high for the whole period, and an active value below the reload never sets it.
- R7: With the concurrent bit set (address 0, bit 1), a write to address 16 loads the shadow registers of all channels, and writes to addresses 17 to 21 are ignored.
- R8: A channel whose field bits [1:0] equal 2 is a capture channel. Bit 2 enables rising edges and bit 3 enables falling edges. The input passes two synchroniser stages, so the captured value is the count after the third clock edge following the input change. The capture sets the channel flag, and the value reads at 16+i.
- R9: An edge detected in the cycle of an overflow captures the reload value.
- R10: Writing a 1 to bit i of address 5 makes capture channel i latch the count that the counter takes at that edge. Channels in other modes ignore the strike.
- R11: Writing 1s to address 4 clears only the written flag bits. A flag event in the same cycle as its clear leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 5 | Register read address |
| rd_data | output | 16 | Register read data (combinational) |
| cap_in | input | 6 | Capture inputs, one per channel (asynchronous) |
| cmp_out | output | 6 | Compare outputs, one per channel |
| irq_ch | output | 6 | Sticky channel interrupt flags |
| irq_ovf | output | 1 | Sticky overflow interrupt flag |

## Verification
The hardest case to reach is the overflow cycle, where several events meet: a shadow transfer, the output reset, the evaluation against the fresh value, and an input edge that must capture the post-overflow count. The reload is kept at 0xFFF0, so a period lasts only sixteen cycles. The stimulus waits on the reference model's count before acting. It toggles a capture input exactly three edges ahead of the wrap and places a compare value equal to the reload. It also times software strikes and timer loads to land on chosen count values. A behavioural model compares every output pin each clock.

// File: rtl/cct_pkg.sv
`timescale 1ns/1ps
package cct_pkg;

    localparam int AW = 5;

    localparam logic [AW-1:0] A_CTRL   = 5'd0;
    localparam logic [AW-1:0] A_RELOAD = 5'd1;
    localparam logic [AW-1:0] A_TIMER  = 5'd2;
    localparam logic [AW-1:0] A_SHEN   = 5'd3;
    localparam logic [AW-1:0] A_FLAGS  = 5'd4;
    localparam logic [AW-1:0] A_SWCAP  = 5'd5;
    localparam logic [AW-1:0] A_CFG0   = 5'd8;
    localparam logic [AW-1:0] A_VAL0   = 5'd16;
    localparam logic [AW-1:0] A_SHD0   = 5'd24;

    typedef enum logic [1:0] {
        CH_IDLE = 2'd0,
        CH_CMP  = 2'd1,
        CH_CAP  = 2'd2,
        CH_RSVD = 2'd3
    } ch_mode_e;

    // packed: mode in [1:0], rising enable in [2], falling enable in [3]
    typedef struct packed {
        logic     on_fall;
        logic     on_rise;
        ch_mode_e mode;
    } ch_cfg_t;

    localparam int CFG_W = $bits(ch_cfg_t);

    function automatic logic [AW-1:0] chan_addr(input logic [AW-1:0] base, input int idx);
        return base + AW'(idx);
    endfunction

    function automatic logic edge_hit(input ch_cfg_t c, input logic rise, input logic fall);
        return (c.on_rise & rise) | (c.on_fall & fall);
    endfunction

endpackage

// File: rtl/cct_timebase.sv
`timescale 1ns/1ps
module cct_timebase #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          ld_en,
    input  logic [TW-1:0] ld_val,
    input  logic [TW-1:0] reload,
    output logic [TW-1:0] cnt_q,
    output logic [TW-1:0] cnt_nxt,
    output logic          ovf,
    output logic          step
);
    localparam logic [TW-1:0] TOP = '1;

    always_comb begin
        step    = run && !ld_en;
        ovf     = step && (cnt_q == TOP);
        cnt_nxt = cnt_q;
        if (ld_en)     cnt_nxt = ld_val;
        else if (ovf)  cnt_nxt = reload;
        else if (step) cnt_nxt = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_nxt;
    end
endmodule

// File: rtl/cct_capsync.sv
`timescale 1ns/1ps
module cct_capsync #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pin,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    logic [W-1:0] s1_q, s2_q, s3_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q <= '0;
            s2_q <= '0;
            s3_q <= '0;
        end else begin
            s1_q <= pin;
            s2_q <= s1_q;
            s3_q <= s2_q;
        end
    end

    assign rise = s2_q & ~s3_q;
    assign fall = ~s2_q & s3_q;
endmodule

// File: rtl/cct_channel.sv
`timescale 1ns/1ps
module cct_channel
    import cct_pkg::*;
#(
    parameter int TW = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             shd_we,
    input  logic [TW-1:0]    shd_wdata,
    input  logic             shen_set,
    input  logic             sw_cap,
    input  logic             rise,
    input  logic             fall,
    input  logic             step,
    input  logic             ovf,
    input  logic [TW-1:0]    cnt_nxt,
    output ch_cfg_t          cfg_q,
    output logic [TW-1:0]    act_q,
    output logic [TW-1:0]    shd_q,
    output logic             shen_q,
    output logic             cmp_out,
    output logic             evt
);
    logic          is_cmp, is_cap, xfer, hit, cap_evt;
    logic [TW-1:0] act_sel;

    always_comb begin
        is_cmp  = (cfg_q.mode == CH_CMP);
        is_cap  = (cfg_q.mode == CH_CAP);
        xfer    = ovf && shen_q && is_cmp;
        act_sel = xfer ? shd_q : act_q;
        hit     = (cnt_nxt == act_sel);
        cap_evt = is_cap && (edge_hit(cfg_q, rise, fall) || sw_cap);
        evt     = (is_cmp && step && hit) || cap_evt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q   <= '0;
            act_q   <= '0;
            shd_q   <= '0;
            shen_q  <= 1'b0;
            cmp_out <= 1'b0;
        end else begin
            if (cfg_we) cfg_q <= ch_cfg_t'(cfg_wdata);
            if (shd_we) shd_q <= shd_wdata;

            if (shen_set)  shen_q <= 1'b1;
            else if (xfer) shen_q <= 1'b0;

            if (cap_evt)   act_q <= cnt_nxt;
            else if (xfer) act_q <= shd_q;

            if (!is_cmp)          cmp_out <= 1'b0;
            else if (ovf)         cmp_out <= hit;
            else if (step && hit) cmp_out <= 1'b1;
        end
    end
endmodule

// File: rtl/cct_unit.sv
`timescale 1ns/1ps
module cct_unit
    import cct_pkg::*;
#(
    parameter int NCH = 6,
    parameter int TW  = 16
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           wr_en,
    input  logic [AW-1:0]  wr_addr,
    input  logic [TW-1:0]  wr_data,
    input  logic [AW-1:0]  rd_addr,
    output logic [TW-1:0]  rd_data,
    input  logic [NCH-1:0] cap_in,
    output logic [NCH-1:0] cmp_out,
    output logic [NCH-1:0] irq_ch,
    output logic           irq_ovf
);
    localparam int FLAG_W = NCH + 1;

    logic           run_q, conc_q, ovf_flag_q;
    logic [TW-1:0]  reload_q, cnt_q, cnt_nxt;
    logic           ovf, step, tmr_ld;
    logic [NCH-1:0] ch_flag_q, rise_v, fall_v, shd_ld, shen_set_v, swcap_v;
    logic [NCH-1:0] shen_q_v, evt_v, cmp_mode_v, clr_ch;
    logic           clr_ovf;
    logic [TW-1:0]  act_v [NCH];
    logic [TW-1:0]  shd_v [NCH];
    ch_cfg_t        cfg_v [NCH];

    always_comb begin
        tmr_ld     = wr_en && (wr_addr == A_TIMER);
        shen_set_v = (wr_en && wr_addr == A_SHEN)  ? wr_data[NCH-1:0] : '0;
        swcap_v    = (wr_en && wr_addr == A_SWCAP) ? wr_data[NCH-1:0] : '0;
        clr_ch     = (wr_en && wr_addr == A_FLAGS) ? wr_data[NCH-1:0] : '0;
        clr_ovf    = wr_en && (wr_addr == A_FLAGS) && wr_data[NCH];
    end

    cct_timebase #(.TW(TW)) u_tb (
        .clk     (clk),
        .rst     (rst),
        .run     (run_q),
        .ld_en   (tmr_ld),
        .ld_val  (wr_data),
        .reload  (reload_q),
        .cnt_q   (cnt_q),
        .cnt_nxt (cnt_nxt),
        .ovf     (ovf),
        .step    (step)
    );

    cct_capsync #(.W(NCH)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .pin  (cap_in),
        .rise (rise_v),
        .fall (fall_v)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        assign shd_ld[i] = wr_en &&
            (conc_q ? (wr_addr == A_VAL0) : (wr_addr == chan_addr(A_VAL0, i)));
        assign cmp_mode_v[i] = (cfg_v[i].mode == CH_CMP);

        cct_channel #(.TW(TW)) u_ch (
            .clk       (clk),
            .rst       (rst),
            .cfg_we    (wr_en && (wr_addr == chan_addr(A_CFG0, i))),
            .cfg_wdata (wr_data[CFG_W-1:0]),
            .shd_we    (shd_ld[i]),
            .shd_wdata (wr_data),
            .shen_set  (shen_set_v[i]),
            .sw_cap    (swcap_v[i]),
            .rise      (rise_v[i]),
            .fall      (fall_v[i]),
            .step      (step),
            .ovf       (ovf),
            .cnt_nxt   (cnt_nxt),
            .cfg_q     (cfg_v[i]),
            .act_q     (act_v[i]),
            .shd_q     (shd_v[i]),
            .shen_q    (shen_q_v[i]),
            .cmp_out   (cmp_out[i]),
            .evt       (evt_v[i])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q      <= 1'b0;
            conc_q     <= 1'b0;
            reload_q   <= '0;
            ch_flag_q  <= '0;
            ovf_flag_q <= 1'b0;
        end else begin
            if (wr_en && wr_addr == A_CTRL) begin
                run_q  <= wr_data[0];
                conc_q <= wr_data[1];
            end
            if (wr_en && wr_addr == A_RELOAD) reload_q <= wr_data;
            ch_flag_q  <= (ch_flag_q & ~clr_ch) | evt_v;
            ovf_flag_q <= (ovf_flag_q & ~clr_ovf) | ovf;
        end
    end

    assign irq_ch  = ch_flag_q;
    assign irq_ovf = ovf_flag_q;

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_CTRL:   rd_data = TW'({conc_q, run_q});
            A_RELOAD: rd_data = reload_q;
            A_TIMER:  rd_data = cnt_q;
            A_SHEN:   rd_data = TW'(shen_q_v);
            A_FLAGS:  rd_data = TW'({ovf_flag_q, ch_flag_q});
            default:  rd_data = '0;
        endcase
        for (int i = 0; i < NCH; i++) begin
            if (rd_addr == chan_addr(A_CFG0, i)) rd_data = TW'(cfg_v[i]);
            if (rd_addr == chan_addr(A_VAL0, i)) rd_data = act_v[i];
            if (rd_addr == chan_addr(A_SHD0, i)) rd_data = shd_v[i];
        end
    end

    logic [FLAG_W-1:0] unused_flag_w;
    assign unused_flag_w = '0;
endmodule

// File: rtl/cct_unit_chk.sv
`timescale 1ns/1ps
module cct_unit_chk #(
    parameter int NCH = 6,
    parameter int TW  = 16
) (
    input logic           clk,
    input logic           rst,
    input logic           ovf,
    input logic           step,
    input logic [TW-1:0]  cnt_q,
    input logic [TW-1:0]  reload_q,
    input logic           irq_ovf,
    input logic [NCH-1:0] cmp_out,
    input logic [NCH-1:0] cmp_mode_v,
    input logic [NCH-1:0] shen_q_v,
    input logic [NCH-1:0] shen_set_v
);
    a_r2_wrap_to_reload: assert property (@(posedge clk) disable iff (rst)
        ovf |=> (cnt_q == $past(reload_q)))
        else $error("R2 counter did not restart from reload");

    a_r2_single_step: assert property (@(posedge clk) disable iff (rst)
        (step && !ovf) |=> (cnt_q == $past(cnt_q) + 1'b1))
        else $error("R2 counter did not advance by one");

    a_r3_ovf_flag: assert property (@(posedge clk) disable iff (rst)
        ovf |=> irq_ovf)
        else $error("R3 overflow flag not raised");

    a_r5_shen_cleared: assert property (@(posedge clk) disable iff (rst)
        ovf |=> ((shen_q_v & $past(cmp_mode_v) & ~$past(shen_set_v)) == '0))
        else $error("R5 transfer enable left set after overflow");

    a_r4_rise_on_step: assert property (@(posedge clk) disable iff (rst)
        (|(cmp_out & ~$past(cmp_out))) |-> $past(step))
        else $error("R4 compare pin rose without a timer step");

    a_r4_fall_on_ovf: assert property (@(posedge clk) disable iff (rst)
        (|(~cmp_out & $past(cmp_out) & $past(cmp_mode_v))) |-> $past(ovf))
        else $error("R4 compare pin fell outside overflow");

    a_r4_low_off_mode: assert property (@(posedge clk) disable iff (rst)
        (|cmp_out) |-> ((cmp_out & ~$past(cmp_mode_v)) == '0))
        else $error("R4 pin high on a non-compare channel");
endmodule

bind cct_unit cct_unit_chk #(.NCH(NCH), .TW(TW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .ovf        (ovf),
    .step       (step),
    .cnt_q      (cnt_q),
    .reload_q   (reload_q),
    .irq_ovf    (irq_ovf),
    .cmp_out    (cmp_out),
    .cmp_mode_v (cmp_mode_v),
    .shen_q_v   (shen_q_v),
    .shen_set_v (shen_set_v)
);

// File: tb/cct_unit_test.sv
`timescale 1ns/1ps
module cct_unit_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [4:0]  rd_addr = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic [5:0]  cap_in = '0;
    logic [5:0]  cmp_out, irq_ch;
    logic        irq_ovf;
    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    cct_unit uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .cap_in(cap_in),
        .cmp_out(cmp_out), .irq_ch(irq_ch), .irq_ovf(irq_ovf)
    );

    // behavioural reference model
    int unsigned m_cnt, m_reload;
    bit          m_run, m_conc, m_oflag;
    bit [3:0]    m_cfg [6];
    int unsigned m_act [6];
    int unsigned m_shd [6];
    bit [5:0]    m_shen, m_out, m_flag, m_s1, m_s2, m_s3;

    always @(posedge clk) begin : m_step
        bit ld, ovf, step, oclr, xf, hit, cap;
        int unsigned cn;
        bit [1:0] mode;
        bit [5:0] rise, fall, sw, shs, clr, ev;
        if (rst) begin
            m_cnt = 0; m_reload = 0; m_run = 0; m_conc = 0; m_oflag = 0;
            m_shen = 0; m_out = 0; m_flag = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0;
            for (int i = 0; i < 6; i++) begin m_cfg[i] = 0; m_act[i] = 0; m_shd[i] = 0; end
        end else begin
            ld   = wr_en && wr_addr == 2;
            ovf  = m_run && !ld && m_cnt == 16'hFFFF;
            step = m_run && !ld;
            cn   = ld ? wr_data : (ovf ? m_reload : (step ? m_cnt + 1 : m_cnt));
            rise = m_s2 & ~m_s3;
            fall = ~m_s2 & m_s3;
            sw   = (wr_en && wr_addr == 5) ? wr_data[5:0] : 6'd0;
            shs  = (wr_en && wr_addr == 3) ? wr_data[5:0] : 6'd0;
            clr  = (wr_en && wr_addr == 4) ? wr_data[5:0] : 6'd0;
            oclr = wr_en && wr_addr == 4 && wr_data[6];
            for (int i = 0; i < 6; i++) begin
                mode = m_cfg[i][1:0];
                xf   = ovf && m_shen[i] && mode == 1;
                hit  = cn == (xf ? m_shd[i] : m_act[i]);
                cap  = mode == 2 && ((m_cfg[i][2] && rise[i]) || (m_cfg[i][3] && fall[i]) || sw[i]);
                ev[i] = (mode == 1 && step && hit) || cap;
                if (mode != 1) m_out[i] = 0;
                else if (ovf)  m_out[i] = hit;
                else if (step && hit) m_out[i] = 1;
                if (cap) m_act[i] = cn;
                else if (xf) m_act[i] = m_shd[i];
                if (shs[i]) m_shen[i] = 1;
                else if (xf) m_shen[i] = 0;
                if (wr_en && (m_conc ? wr_addr == 16 : wr_addr == 16 + i)) m_shd[i] = wr_data;
                if (wr_en && wr_addr == 8 + i) m_cfg[i] = wr_data[3:0];
            end
            m_flag  = (m_flag & ~clr) | ev;
            m_oflag = (m_oflag & ~oclr) | ovf;
            if (wr_en && wr_addr == 0) begin m_run = wr_data[0]; m_conc = wr_data[1]; end
            if (wr_en && wr_addr == 1) m_reload = wr_data;
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = cap_in;
            m_cnt = cn;
        end
    end

    function automatic int unsigned mread(input int a);
        if (a == 0) return {m_conc, m_run};
        if (a == 1) return m_reload;
        if (a == 2) return m_cnt;
        if (a == 3) return m_shen;
        if (a == 4) return {m_oflag, m_flag};
        if (a >= 8  && a < 14) return m_cfg[a-8];
        if (a >= 16 && a < 22) return m_act[a-16];
        if (a >= 24 && a < 30) return m_shd[a-24];
        return 0;
    endfunction

    function automatic void chk(input bit ok, input string tag, input int unsigned act, input int unsigned exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endfunction

    // per-cycle comparison of the pins against the model
    always @(negedge clk) begin
        if (!rst) begin
            chk(cmp_out === m_out, "R4 cmp_out", cmp_out, m_out);
            chk(irq_ch === m_flag, "R8 irq_ch", irq_ch, m_flag);
            chk(irq_ovf === m_oflag, "R3 irq_ovf", irq_ovf, m_oflag);
        end
    end

    task automatic wr(input int a, input int unsigned d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 5'(a); wr_data = 16'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rdexp(input int a, input int unsigned exp, input string tag);
        rd_addr = 5'(a);
        #1;
        chk(rd_data == 16'(exp), tag, rd_data, exp);
        chk(rd_data == 16'(mread(a)), tag, rd_data, mread(a));
    endtask

    task automatic wait_cnt(input int unsigned v);
        @(negedge clk);
        while (m_cnt != v) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog R2 actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        rdexp(0, 0, "R1 ctrl");
        rdexp(2, 0, "R1 timer");
        rdexp(4, 0, "R1 flags");
        rdexp(16, 0, "R1 active");
        chk(cmp_out == 0 && irq_ovf == 0, "R1 pins", cmp_out, 0);

        wr(1, 16'hFFF0);
        wr(8, 1); wr(9, 1); wr(10, 1); wr(11, 1);
        wr(12, 6); wr(13, 14);
        rdexp(12, 6, "R8 cfg readback");
        wr(16, 16'hFFF8); wr(17, 16'hFFF0); wr(18, 16'hFF00); wr(19, 16'hFFFA);
        rdexp(16, 0, "R5 active held");
        rdexp(24, 16'hFFF8, "R5 shadow");
        wr(3, 6'h07);
        wr(2, 16'hFFF0);
        rdexp(2, 16'hFFF0, "R2 load");
        wr(0, 1);

        wait_cnt(16'hFFFF);
        rdexp(3, 7, "R5 enable pending");
        rdexp(16, 0, "R5 no early transfer");
        @(negedge clk);
        rdexp(2, 16'hFFF0, "R2 wrap");
        rdexp(16, 16'hFFF8, "R5 transferred");
        rdexp(3, 0, "R5 enable cleared");
        rdexp(19, 0, "R5 no enable no transfer");
        chk(cmp_out[1] == 1'b1, "R6 equal reload high", cmp_out[1], 1);
        chk(irq_ovf == 1'b1, "R3 ovf flag", irq_ovf, 1);

        wait_cnt(16'hFFF7);
        chk(cmp_out[0] == 1'b0, "R4 before match", cmp_out[0], 0);
        @(negedge clk);
        chk(cmp_out[0] == 1'b1, "R4 at match", cmp_out[0], 1);
        chk(irq_ch[0] == 1'b1, "R4 match flag", irq_ch[0], 1);
        chk(cmp_out[1] == 1'b1, "R6 whole period", cmp_out[1], 1);
        chk(cmp_out[2] == 1'b0, "R6 below reload", cmp_out[2], 0);
        wait_cnt(16'hFFF0);
        chk(cmp_out[0] == 1'b0, "R4 reset at ovf", cmp_out[0], 0);

        wr(4, 16'h0040);
        rdexp(4, mread(4), "R11 partial clear");
        chk(rd_data[0] == 1'b1, "R11 other flag kept", rd_data[0], 1);

        // R7 concurrent update
        wr(0, 3);
        wr(16, 16'hFFF4);
        rdexp(29, 16'hFFF4, "R7 fan-out ch5");
        rdexp(25, 16'hFFF4, "R7 fan-out ch1");
        wr(17, 16'h1234);
        rdexp(25, 16'hFFF4, "R7 other write ignored");
        wr(3, 6'h0F);
        wait_cnt(16'hFFF1);
        rdexp(17, 16'hFFF4, "R7 ch1 active");
        rdexp(19, 16'hFFF4, "R7 ch3 active");
        wr(0, 1);

        // R8 capture on edges
        wait_cnt(16'hFFF2);
        cap_in[4] = 1'b1;
        repeat (4) @(negedge clk);
        rdexp(20, 16'hFFF5, "R8 rising capture");
        chk(irq_ch[4] == 1'b1, "R8 capture flag", irq_ch[4], 1);
        wait_cnt(16'hFFF2);
        cap_in[4] = 1'b0;
        repeat (5) @(negedge clk);
        rdexp(20, 16'hFFF5, "R8 falling ignored");
        wait_cnt(16'hFFF6);
        cap_in[5] = 1'b1;
        repeat (4) @(negedge clk);
        rdexp(21, 16'hFFF9, "R8 both rising");
        wait_cnt(16'hFFF1);
        cap_in[5] = 1'b0;
        repeat (4) @(negedge clk);
        rdexp(21, 16'hFFF4, "R8 both falling");

        // R9 edge together with overflow
        wait_cnt(16'hFFFD);
        cap_in[4] = 1'b1;
        repeat (4) @(negedge clk);
        rdexp(20, 16'hFFF0, "R9 post-overflow value");

        // R10 software capture
        wait_cnt(16'hFFF3);
        wr(5, 6'h11);
        rdexp(20, 16'hFFF5, "R10 strike value");
        rdexp(16, 16'hFFF4, "R10 compare channel ignores");

        // R2 load while running
        wr(2, 16'hFFE0);
        rdexp(2, 16'hFFE0, "R2 load running");
        @(negedge clk);
        rdexp(2, 16'hFFE1, "R2 step after load");

        repeat (100) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule